// File: doc/BRIEF.md
# Serial Audio Word Capture

This block turns a two-channel serial audio stream into parallel samples. It runs on a master audio clock at 128 times the sample rate, together with a word clock at the sample rate that is locked to the video timing. It derives an internal bit clock at half the master rate. Each half of the word clock carries one channel. A complete word is emitted as a single-cycle strobe with the sample, a channel flag, and the validity, user and channel-status bits and the block-start flag. The control bits are taken at the rising word clock edge.

A three-bit format input picks one of four word-clocked layouts. These are left-justified with left channel on the high level, a one-bit-delayed layout with left on the low level, right-justified, and left-justified with left on the low level. Code 100 marks the biphase-coded mode, which is handled elsewhere. In that mode, and for codes 101 to 111, this block stays silent. A width select picks 24-bit or 20-bit words, and a mute input zeroes the sample data.

Top module: `aud_serial_capture`

## Requirements
- R1: While reset is asserted and after its release, until the first word completes, `smp_valid`, `smp_right`, `smp_data` and the four control outputs are all zero.
- R2: Every word clock transition starts a half period of 64 master cycles, which is 32 bit slots of 2 master cycles each. Slot k covers master cycles 2k and 2k+1 after the transition, and the data input is sampled in cycle 2k+1. `smp_valid` goes high for one cycle, in the cycle that follows the sample of the last bit of a word.
- R3: Format 000: the left channel is sent while the word clock is high, MSB first, in slots 0 to W-1.
- R4: Format 001: the left channel is sent while the word clock is low, MSB first, in slots 1 to W.
- R5: Format 010: the left channel is sent while the word clock is high, MSB first, and the LSB sits in slot 31, so the word occupies slots 32-W to 31.
- R6: Format 011: the left channel is sent while the word clock is low, MSB first, in slots 0 to W-1.
- R7: W is 24 when `wide` is 1 and 20 when it is 0. A 20-bit word appears in `smp_data[23:4]` and bits [3:0] read zero.
- R8: For each word clock period there is exactly one strobe per channel, and two strobes are never adjacent. `smp_right` is 0 for the left channel and 1 for the right channel.
- R9: `smp_v`, `smp_u` and `smp_c` take `ctl_v`, `ctl_u` and `ctl_c` as they stand in the first master cycle after a rising word clock edge. They change at no other time.
- R10: `smp_blk` takes `blk_start` with the same timing as R9.
- R11: When `mute` is 1 in the cycle that samples a word's last bit, that word's strobe carries `smp_data` equal to zero. The strobe still occurs.
- R12: For format codes 100 to 111, no strobe is produced and the four control outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock, 128 fs |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk | input | 1 | Word clock, synchronous to mclk |
| sdata | input | 1 | Serial audio data |
| mode | input | 3 | Format code |
| wide | input | 1 | 1 selects 24-bit words, 0 selects 20-bit words |
| mute | input | 1 | Forces output sample data to zero |
| ctl_v | input | 1 | Validity bit |
| ctl_u | input | 1 | User bit |
| ctl_c | input | 1 | Channel-status bit |
| blk_start | input | 1 | Start of channel-status block |
| smp_valid | output | 1 | One-cycle strobe for a completed word |
| smp_right | output | 1 | Channel of the strobed word, 1 for right |
| smp_data | output | 24 | Sample, MSB-aligned |
| smp_v | output | 1 | Latched validity bit |
| smp_u | output | 1 | Latched user bit |
| smp_c | output | 1 | Latched channel-status bit |
| smp_blk | output | 1 | Latched block-start flag |

## Verification
The half-period counter can drift from the word clock, and the capture window can sit one slot off. Either fault shows on the very next strobe, because the strobe arrives in the wrong cycle and the sample is shifted by one bit. A wrong channel assignment flips `smp_right` within one word period. A latch of the control bits at the wrong edge shows on the first strobe after the control inputs change. A leak from an unused format shows as an unexpected strobe inside one half period.

// File: rtl/aud_cap_pkg.sv
package aud_cap_pkg;
   localparam logic [1:0] FMT_LJ_HI = 2'd0;
   localparam logic [1:0] FMT_DLY1  = 2'd1;
   localparam logic [1:0] FMT_RJ    = 2'd2;
   localparam logic [1:0] FMT_LJ_LO = 2'd3;

   // Left channel rides on the high word clock level for these formats.
   function automatic logic left_on_high(input logic [1:0] fmt);
      return (fmt == FMT_LJ_HI) || (fmt == FMT_RJ);
   endfunction
endpackage

// File: rtl/aud_slot_timer.sv
module aud_slot_timer #(
   parameter int HALF_SLOTS = 32,
   localparam int SW = $clog2(HALF_SLOTS),
   localparam int CW = $clog2(2 * HALF_SLOTS) + 1
) (
   input  logic          mclk,
   input  logic          rst_n,
   input  logic          wclk,
   output logic          tick,
   output logic [SW-1:0] slot,
   output logic          rise
);
   logic          wclk_q;
   logic [CW-1:0] mcnt;
   logic [CW-1:0] idx;
   logic          edge_now;

   assign edge_now = wclk ^ wclk_q;
   assign idx      = edge_now ? '0 : mcnt;
   assign tick     = idx[0] && (idx < CW'(2 * HALF_SLOTS));
   assign slot     = idx[SW:1];
   assign rise     = edge_now && wclk;

   always_ff @(posedge mclk) begin
      if (!rst_n) begin
         wclk_q <= 1'b0;
         mcnt   <= '0;
      end else begin
         wclk_q <= wclk;
         if (edge_now)
            mcnt <= CW'(1);
         else if (mcnt != {CW{1'b1}})
            mcnt <= mcnt + CW'(1);
      end
   end
endmodule

// File: rtl/aud_word_shift.sv
module aud_word_shift #(
   parameter int MAX_W = 24
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             sd,
   output logic [MAX_W-1:0] word
);
   logic [MAX_W-2:0] sr;

   assign word = {sr, sd};

   always_ff @(posedge mclk) begin
      if (!rst_n)
         sr <= '0;
      else if (shift_en)
         sr <= word[MAX_W-2:0];
   end
endmodule

// File: rtl/aud_ctl_latch.sv
module aud_ctl_latch #(
   parameter int N = 4
) (
   input  logic         mclk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   always_ff @(posedge mclk) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end
endmodule

// File: rtl/aud_serial_capture.sv
module aud_serial_capture #(
   parameter int HALF_SLOTS = 32,
   parameter int MAX_W      = 24,
   parameter int MIN_W      = 20,
   parameter bit MSB_ALIGN  = 1'b1
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic             wclk,
   input  logic             sdata,
   input  logic [2:0]       mode,
   input  logic             wide,
   input  logic             mute,
   input  logic             ctl_v,
   input  logic             ctl_u,
   input  logic             ctl_c,
   input  logic             blk_start,
   output logic             smp_valid,
   output logic             smp_right,
   output logic [MAX_W-1:0] smp_data,
   output logic             smp_v,
   output logic             smp_u,
   output logic             smp_c,
   output logic             smp_blk
);
   import aud_cap_pkg::*;

   localparam int SW  = $clog2(HALF_SLOTS);
   localparam int LW  = SW + 2;
   localparam int PAD = MAX_W - MIN_W;

   generate
      if (MIN_W >= MAX_W) begin : g_bad_width
         $error("MIN_W must be below MAX_W");
      end
      if (MAX_W > HALF_SLOTS - 1) begin : g_bad_slots
         $error("word must fit in a half period with one delay slot");
      end
   endgenerate

   logic             tick, rise;
   logic [SW-1:0]    slot;
   logic             fmt_ok;
   logic [LW-1:0]    wlen, win_lo, win_hi, slot_x;
   logic             in_win, done;
   logic [MAX_W-1:0] word, aligned;
   logic [3:0]       ctl_q;

   aud_slot_timer #(.HALF_SLOTS(HALF_SLOTS)) timer_i (
      .mclk(mclk), .rst_n(rst_n), .wclk(wclk),
      .tick(tick), .slot(slot), .rise(rise)
   );

   assign fmt_ok = !mode[2];
   assign wlen   = wide ? LW'(MAX_W) : LW'(MIN_W);
   assign slot_x = {2'b00, slot};

   always_comb begin
      unique case (mode[1:0])
         FMT_DLY1: win_lo = LW'(1);
         FMT_RJ:   win_lo = LW'(HALF_SLOTS) - wlen;
         default:  win_lo = '0;
      endcase
      win_hi = win_lo + wlen - LW'(1);
   end

   assign in_win = fmt_ok && tick && (slot_x >= win_lo) && (slot_x <= win_hi);
   assign done   = in_win && (slot_x == win_hi);

   aud_word_shift #(.MAX_W(MAX_W)) shift_i (
      .mclk(mclk), .rst_n(rst_n), .shift_en(in_win), .sd(sdata), .word(word)
   );

   generate
      if (MSB_ALIGN) begin : g_msb
         assign aligned = wide ? word : {word[MIN_W-1:0], {PAD{1'b0}}};
      end else begin : g_lsb
         assign aligned = wide ? word : {{PAD{1'b0}}, word[MIN_W-1:0]};
      end
   endgenerate

   always_ff @(posedge mclk) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_right <= 1'b0;
         smp_data  <= '0;
      end else begin
         smp_valid <= done;
         if (done) begin
            smp_data  <= mute ? '0 : aligned;
            smp_right <= (wclk != left_on_high(mode[1:0]));
         end
      end
   end

   aud_ctl_latch #(.N(4)) ctl_i (
      .mclk(mclk), .rst_n(rst_n), .load(rise && fmt_ok),
      .d({ctl_v, ctl_u, ctl_c, blk_start}), .q(ctl_q)
   );

   assign {smp_v, smp_u, smp_c, smp_blk} = ctl_q;
endmodule

// File: rtl/aud_serial_capture_chk.sv
module aud_serial_capture_chk #(
   parameter int MAX_W = 24,
   parameter int MIN_W = 20
) (
   input logic             mclk,
   input logic             rst_n,
   input logic             wclk,
   input logic [2:0]       mode,
   input logic             wide,
   input logic             mute,
   input logic             smp_valid,
   input logic [MAX_W-1:0] smp_data,
   input logic             smp_v,
   input logic             smp_u,
   input logic             smp_c,
   input logic             smp_blk
);
   localparam int PAD = MAX_W - MIN_W;

   // R12
   a_r12_no_strobe_unused: assert property (@(posedge mclk) disable iff (!rst_n)
      mode[2] |=> !smp_valid);

   // R11
   a_r11_mute_zero: assert property (@(posedge mclk) disable iff (!rst_n)
      (smp_valid && $past(mute)) |-> (smp_data == '0));

   // R8
   a_r8_no_back_to_back: assert property (@(posedge mclk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);

   // R7
   a_r7_pad_zero: assert property (@(posedge mclk) disable iff (!rst_n)
      (smp_valid && !$past(wide)) |-> (smp_data[PAD-1:0] == '0));

   // R9, R10
   a_r9_ctl_hold: assert property (@(posedge mclk) disable iff (!rst_n)
      !($past(wclk) && !$past(wclk, 2) && !$past(mode[2]))
      |-> $stable({smp_v, smp_u, smp_c, smp_blk}));
endmodule

bind aud_serial_capture aud_serial_capture_chk #(.MAX_W(MAX_W), .MIN_W(MIN_W)) chk_i (
   .mclk(mclk), .rst_n(rst_n), .wclk(wclk), .mode(mode), .wide(wide), .mute(mute),
   .smp_valid(smp_valid), .smp_data(smp_data), .smp_v(smp_v), .smp_u(smp_u),
   .smp_c(smp_c), .smp_blk(smp_blk)
);

// File: tb/aud_serial_capture_tb_top.sv
`timescale 1ns/1ps
module aud_serial_capture_tb_top;
   logic        mclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wclk = 1'b0, sdata = 1'b0, wide = 1'b0, mute = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        ctl_v = 1'b0, ctl_u = 1'b0, ctl_c = 1'b0, blk_start = 1'b0;
   logic        smp_valid, smp_right, smp_v, smp_u, smp_c, smp_blk;
   logic [23:0] smp_data;

   int n_chk = 0, n_fail = 0, nstb = 0, wn = 0;
   int prev_i = 0, exp_last_i = 0;
   logic [23:0] exp_data = '0;
   logic        exp_right = 1'b0, exp_mute = 1'b0, exp_wide = 1'b0;
   logic [3:0]  exp_ctl = '0;
   string       exp_tag = "R3";
   bit          finished = 0;

   always #2.5 mclk = ~mclk;

   aud_serial_capture dut_i (
      .mclk(mclk), .rst_n(rst_n), .wclk(wclk), .sdata(sdata), .mode(mode),
      .wide(wide), .mute(mute), .ctl_v(ctl_v), .ctl_u(ctl_u), .ctl_c(ctl_c),
      .blk_start(blk_start), .smp_valid(smp_valid), .smp_right(smp_right),
      .smp_data(smp_data), .smp_v(smp_v), .smp_u(smp_u), .smp_c(smp_c),
      .smp_blk(smp_blk)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic monitor();
      if (smp_valid) begin
         nstb++;
         check(prev_i == exp_last_i, "R2 strobe cycle", prev_i, exp_last_i);
         check(smp_data == exp_data, exp_mute ? "R11 muted data" : exp_tag, smp_data, exp_data);
         if (!exp_wide)
            check(smp_data[3:0] == 4'd0, "R7 pad bits", smp_data[3:0], 0);
         check(smp_right == exp_right, "R8 channel flag", smp_right, exp_right);
         check({smp_v, smp_u, smp_c} == exp_ctl[3:1], "R9 control bits",
               {smp_v, smp_u, smp_c}, exp_ctl[3:1]);
         check(smp_blk == exp_ctl[0], "R10 block flag", smp_blk, exp_ctl[0]);
      end
   endtask

   task automatic run_word(input logic [2:0] m, input bit w24, input bit mu);
      int wl = w24 ? 24 : 20;
      int st = (m[1:0] == 2'd1) ? 1 : (m[1:0] == 2'd2) ? 32 - wl : 0;
      bit left_hi = (m[1:0] == 2'd0) || (m[1:0] == 2'd2);
      logic [23:0] msk = w24 ? 24'hFFFFFF : 24'h0FFFFF;
      logic [23:0] s_l = 24'(wn * 32'h0019660D + 32'h3C6EF35F) & msk;
      logic [23:0] s_r = (s_l ^ 24'hA5C3F1) & msk;
      for (int h = 0; h < 2; h++) begin
         bit lvl = (h == 0);
         bit is_left = (lvl == left_hi);
         logic [23:0] s = is_left ? s_l : s_r;
         for (int i = 0; i < 64; i++) begin
            int k = i / 2;
            @(negedge mclk);
            monitor();
            wclk = lvl;
            if (k >= st && k < st + wl) sdata = s[wl - 1 - (k - st)];
            else sdata = (k % 3 == 0);
            if (h == 0 && i == 0) begin
               ctl_v = wn[0]; ctl_u = wn[1]; ctl_c = wn[2] ^ wn[0];
               blk_start = (wn % 5 == 0);
               if (!m[2]) exp_ctl = {ctl_v, ctl_u, ctl_c, blk_start};
            end
            prev_i = i;
            exp_last_i = 2 * (st + wl - 1) + 1;
            exp_right = !is_left;
            exp_wide = w24;
            exp_mute = mu;
            exp_data = mu ? 24'd0 : (w24 ? s : (s << 4));
            case (m[1:0])
               2'd0: exp_tag = "R3 format 000 data";
               2'd1: exp_tag = "R4 format 001 data";
               2'd2: exp_tag = "R5 format 010 data";
               default: exp_tag = "R6 format 011 data";
            endcase
         end
      end
      wn++;
   endtask

   task automatic run_seq(input logic [2:0] m, input bit w24, input bit mu, input int nw);
      int n0 = nstb;
      mode = m; wide = w24; mute = mu;
      for (int j = 0; j < nw; j++) run_word(m, w24, mu);
      @(negedge mclk);
      monitor();
      wclk = 1'b0; sdata = 1'b0; prev_i = 64;
      check(nstb - n0 == (m[2] ? 0 : 2 * nw), m[2] ? "R12 strobe count" : "R8 strobe count",
            nstb - n0, m[2] ? 0 : 2 * nw);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [3:0] saved;
      repeat (4) @(negedge mclk);
      check({smp_valid, smp_right, smp_data, smp_v, smp_u, smp_c, smp_blk} == '0,
            "R1 outputs in reset", smp_data, 0);
      rst_n = 1'b1;
      @(negedge mclk);
      check({smp_valid, smp_right, smp_data, smp_v, smp_u, smp_c, smp_blk} == '0,
            "R1 outputs after reset", smp_data, 0);
      for (int m = 0; m < 4; m++)
         for (int w = 0; w < 2; w++)
            run_seq(3'(m), w[0], 1'b0, 3);
      run_seq(3'd0, 1'b1, 1'b1, 2);
      run_seq(3'd2, 1'b0, 1'b1, 2);
      run_seq(3'd1, 1'b1, 1'b0, 6);
      saved = {smp_v, smp_u, smp_c, smp_blk};
      for (int m = 4; m < 8; m++) begin
         run_seq(3'(m), m[0], 1'b0, 1);
         check({smp_v, smp_u, smp_c, smp_blk} == saved, "R12 control frozen",
               {smp_v, smp_u, smp_c, smp_blk}, saved);
      end
      run_seq(3'd3, 1'b1, 1'b0, 2);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule